// File: doc/BRIEF.md
# Round-Robin Grant Selector

This block picks one winner per cycle from a vector of N requesters. The order is fair and rotates. A stored pointer records the index that won most recently. The search starts at the first index above the pointer and runs upward. If no requester above the pointer is asserting, the search wraps around to the lowest asserting index.

The winning index appears combinationally on `grant`. The pointer value for the next cycle appears on `ptr_next`, and the pointer register loads it on every clock edge. The selection does not step through the requesters one at a time in a chain N stages long. Instead it builds a mask of the positions above the pointer and applies it to the requests. Two tree-shaped trailing-zero counters then run side by side, one on the masked requests and one on all requests, and a final select chooses between their results. The logic depth therefore grows with log2(N). N need not be a power of two. Pointer values at or above N never occur.

Top module: `rr_arbiter`

## Requirements
- R1: When at least one request bit at an index strictly greater than `ptr` is set, `grant` equals the lowest such index.
- R2: When requests are set but none lies above `ptr`, `grant` equals the lowest set request index overall.
- R3: When `req` is all zero, `grant` is 0.
- R4: `ptr_next` equals `grant` whenever any request is set. When `req` is all zero, `ptr_next` equals `ptr`.
- R5: On every rising clock edge out of reset, `ptr` takes the value that `ptr_next` had before the edge.
- R6: While `rst_n` is low, `ptr` is N-1. Index 0 therefore has first priority once reset is released.
- R7: R1 to R4 hold for every pointer value from 0 to N-1, including when N is not a power of two. `grant` is always below N.
- R8: The search runs upward from the pointer. A set request just above `ptr` wins over any set request at or below `ptr`, even when the lower one has a smaller index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N | Request vector; bit i is requester i |
| grant | output | clog2(N) | Index of the winning requester (0 when idle) |
| ptr_next | output | clog2(N) | Pointer value to be loaded at the next edge |
| ptr | output | clog2(N) | Current stored pointer |

## Verification
The hardest part is pairing an arbitrary pointer value with an arbitrary request pattern, because the pointer can only be moved through the request port. The bench first drives a one-hot request at the target index for one cycle, which parks the pointer there whatever its previous value. On the next cycle it applies the request pattern under test. Repeating this for every pointer value from 0 to N-1 and every request pattern of a six-requester instance covers the wrap case, the idle case, and the case with the pointer at N-1 (where nothing lies above it), all against a model that walks the indices one by one.

// File: rtl/rr_pkg.sv
package rr_pkg;
   // Width of an index into an n-entry vector; at least one bit.
   function automatic int ptr_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rr_thresh_mask.sv
module rr_thresh_mask #(
   parameter int N = 6,
   parameter int W = rr_pkg::ptr_width(N)
) (
   input  logic [W-1:0] thresh,
   output logic [N-1:0] above
);
   // Each bit is an independent comparator against a constant: one level of
   // compare logic, no chain between positions.
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign above[i] = (W'(i) > thresh);
   end
endmodule

// File: rtl/rr_ctz.sv
module rr_ctz #(
   parameter int N = 6,
   parameter int W = rr_pkg::ptr_width(N)
) (
   input  logic [N-1:0] vec,
   output logic [W-1:0] idx,
   output logic         any
);
   localparam int P = 1 << W;

   logic [P-1:0] padded;

   if (P == N) begin : g_exact
      assign padded = vec;
   end else begin : g_pad
      assign padded = {{(P-N){1'b0}}, vec};
   end

   // Binary reduction: each node merges a lower and an upper half, keeping the
   // lower half's index when it has a set bit.
   function automatic logic [W:0] tree(input logic [P-1:0] v);
      logic [P-1:0]        f;
      logic [P-1:0][W-1:0] x;
      f = v;
      x = '0;
      for (int l = 1; l <= W; l++) begin
         for (int j = 0; j < (P >> l); j++) begin
            if (f[2*j]) x[j] = x[2*j];
            else        x[j] = x[2*j+1] | W'(1 << (l-1));
            f[j] = f[2*j] | f[2*j+1];
         end
      end
      return {f[0], x[0]};
   endfunction

   logic [W:0] res;
   assign res = tree(padded);
   assign any = res[W];
   assign idx = res[W-1:0];
endmodule

// File: rtl/rr_core.sv
module rr_core #(
   parameter int N = 6,
   parameter int W = rr_pkg::ptr_width(N)
) (
   input  logic [N-1:0] req,
   input  logic [W-1:0] ptr,
   output logic [W-1:0] grant,
   output logic [W-1:0] ptr_next
);
   logic [N-1:0] above;
   logic [N-1:0] req_hi;
   logic [W-1:0] idx_hi, idx_all;
   logic         any_hi, any_all;

   rr_thresh_mask #(.N(N), .W(W)) u_mask (
      .thresh (ptr),
      .above  (above)
   );

   assign req_hi = req & above;

   rr_ctz #(.N(N), .W(W)) u_ctz_hi (
      .vec (req_hi),
      .idx (idx_hi),
      .any (any_hi)
   );

   rr_ctz #(.N(N), .W(W)) u_ctz_all (
      .vec (req),
      .idx (idx_all),
      .any (any_all)
   );

   logic [W-1:0] pick;
   assign pick     = any_hi ? idx_hi : idx_all;
   assign grant    = any_all ? pick : '0;
   assign ptr_next = any_all ? pick : ptr;
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
   parameter  int N = 6,
   localparam int W = rr_pkg::ptr_width(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [W-1:0] grant,
   output logic [W-1:0] ptr_next,
   output logic [W-1:0] ptr
);
   if (N < 2) begin : g_bad_n
      $error("rr_arbiter: N must be at least 2");
   end

   localparam logic [W-1:0] PTR_RST = W'(N - 1);

   rr_core #(.N(N), .W(W)) u_core (
      .req      (req),
      .ptr      (ptr),
      .grant    (grant),
      .ptr_next (ptr_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= PTR_RST;
      else        ptr <= ptr_next;
   end
endmodule

// File: rtl/rr_arbiter_chk.sv
module rr_arbiter_chk #(
   parameter  int N = 6,
   localparam int W = rr_pkg::ptr_width(N)
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] req,
   input logic [W-1:0] grant,
   input logic [W-1:0] ptr_next,
   input logic [W-1:0] ptr
);
   // Requests strictly between the pointer and the grant (upward, no wrap).
   logic [N-1:0] skipped;
   logic         hit;
   always_comb begin
      skipped = '0;
      hit     = 1'b0;
      for (int i = 0; i < N; i++) begin
         skipped[i] = req[i] && (i > int'(ptr)) && (i < int'(grant));
         if (i == int'(grant)) hit = req[i];
      end
   end

   a_r3_idle_grant_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |-> (grant == '0));

   a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |-> (ptr_next == ptr));

   a_r4_follow_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (ptr_next == grant));

   a_r1_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> hit);

   a_r8_no_skip_upward: assert property (@(posedge clk) disable iff (!rst_n)
      (grant > ptr) |-> (skipped == '0));

   a_r7_grant_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(grant) < N);

   a_r5_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (ptr == $past(ptr_next)));

   a_r6_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (int'(ptr) == N - 1));
endmodule

bind rr_arbiter rr_arbiter_chk #(.N(N)) u_chk (.*);

// File: tb/rr_arbiter_tb.sv
module rr_arbiter_tb;
   localparam int N = 6;
   localparam int W = rr_pkg::ptr_width(N);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [W-1:0] grant, ptr_next, ptr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rr_arbiter #(.N(N)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .grant    (grant),
      .ptr_next (ptr_next),
      .ptr      (ptr)
   );

   // Serial wrap-around model: walk upward from p+1, first set bit wins.
   function automatic int model_grant(input int r, input int p);
      for (int k = 1; k <= N; k++) begin
         int i = (p + k) % N;
         if (r[i]) return i;
      end
      return 0;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R6: pointer held at N-1 during reset
      check(int'(ptr) == N - 1, "R6 reset ptr", int'(ptr), N - 1);
      rst_n = 1'b1;
      req = '1;
      #1;
      // R6: index 0 first after reset
      check(int'(grant) == 0, "R6 first grant", int'(grant), 0);
      @(negedge clk);
      check(int'(ptr) == 0, "R5 load after reset", int'(ptr), 0);

      for (int p = 0; p < N; p++) begin
         for (int r = 0; r < (1 << N); r++) begin
            int eg, en;
            req = N'(1 << p);
            @(negedge clk);
            check(int'(ptr) == p, "R5 park ptr", int'(ptr), p);
            req = N'(r);
            #1;
            eg = (r == 0) ? 0 : model_grant(r, p);
            en = (r == 0) ? p : eg;
            if (r == 0)
               check(int'(grant) == 0, "R3 idle grant", int'(grant), 0);
            else if ((r >> (p + 1)) != 0)
               check(int'(grant) == eg, "R1 R8 upward grant", int'(grant), eg);
            else
               check(int'(grant) == eg, "R2 wrap grant", int'(grant), eg);
            check(int'(ptr_next) == en, "R4 next ptr", int'(ptr_next), en);
            check(int'(grant) < N, "R7 grant range", int'(grant), N - 1);
            @(negedge clk);
            check(int'(ptr) == en, "R5 ptr update", int'(ptr), en);
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule